// File: doc/BRIEF.md
# Power Controller Status and Interrupt Latch

This block sits between three supply-monitor comparators (battery pack present, 3.3 V rail fault, charger present) and the serial control port of a power-management controller. It masks each comparator according to the current operating mode, registers the masked value as a status bit, and keeps one sticky interrupt flag per comparator. Each flag has its own set rule. A flag stays set until the serial port sends a clear pulse for it.

The three flags are ORed onto a single interrupt line for the host CPU. The six status bits are presented as a parallel word in the order the serial shifter sends them, so the shifter can load the word directly. In the first clock after reset the flags are loaded from the charger state, so the host gets an interrupt at power-up whether or not a charger is connected.

Operating mode encoding on `mode_i`: 2'b00 shutdown, 2'b01 low power, 2'b10 standby, 2'b11 operate. Channel index on `raw_i` and `clr_i`: bit 0 is battery, bit 1 is the 3.3 V fault, bit 2 is the charger.

Top module: `status_irq_ctrl`

## Requirements
- R1: The battery status reads 0 whenever the mode is shutdown or low power, whatever the battery comparator says.
- R2: The 3.3 V fault status reads 0 in every mode other than operate.
- R3: The charger status reads 0 in shutdown only. It follows its comparator in the low power, standby and operate modes.
- R4: Any change of the masked battery status from one cycle to the next sets the battery flag. A change caused by mode masking counts as a change.
- R5: Only a 0-to-1 change of the masked 3.3 V fault status sets its flag. A 1-to-0 change leaves the flag as it was.
- R6: Any change of the masked charger status sets the charger flag.
- R7: A 1 on `clr_i[i]` clears flag i on the next clock edge, unless a set event occurs for that flag in the same cycle. With no clear and no event, a flag holds its value.
- R8: When a clear and a set event hit the same flag in the same cycle, the flag stays set.
- R9: While reset is held, `status_o` and `irq_o` are 0. On the first clock edge after reset, the flags load their power-up values and clears are ignored. The battery flag becomes the inverse of the masked charger status, the charger flag becomes the masked charger status, and the 3.3 V fault flag becomes 0.
- R10: `irq_o` is 1 exactly when at least one of the three flags is 1.
- R11: `status_o` bit 5 is the battery flag, bit 4 the battery status, bit 3 the 3.3 V fault flag, bit 2 the 3.3 V fault status, bit 1 the charger flag and bit 0 the charger status.
- R12: Status bits and flags appear on the outputs one clock edge after the inputs that cause them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode (00 shutdown, 01 low power, 10 standby, 11 operate) |
| raw_i | input | 3 | Comparator outputs: [0] battery, [1] 3.3 V fault, [2] charger |
| clr_i | input | 3 | Flag clear pulses, same bit order as raw_i |
| irq_o | output | 1 | OR of the three flags |
| status_o | output | 6 | Flags and statuses in serial output order |

## Verification
Each status bit is also the edge-detection reference for its flag. A wrong registered status therefore shows on `status_o` on the next edge, and it also causes a false or missed flag on that same edge, which reaches `irq_o` at once. A flag stuck in the wrong state shows on both `status_o` and `irq_o` until a clear or a new event arrives. For that reason the bench compares every output against its own model on every cycle rather than only at the end of a directed step. The power-up load happens only once, in the first cycle after reset, so it is checked explicitly right after reset is released.

// File: rtl/status_irq_pkg.sv
package status_irq_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_LOWPWR  = 2'b01,
    MODE_STANDBY = 2'b10,
    MODE_RUN     = 2'b11
  } pwr_mode_e;

  localparam int unsigned NUM_CH  = 3;
  localparam int unsigned CH_BATT = 0;
  localparam int unsigned CH_REG  = 1;
  localparam int unsigned CH_CHG  = 2;
  localparam int unsigned ST_W    = 2 * NUM_CH;
endpackage

// File: rtl/status_gate.sv
module status_gate
  import status_irq_pkg::*;
(
  input  logic [1:0]        mode_i,
  input  logic [NUM_CH-1:0] raw_i,
  output logic [NUM_CH-1:0] gated_o
);
  pwr_mode_e mode;
  logic      on_batt, on_reg, on_chg;

  always_comb begin
    mode    = pwr_mode_e'(mode_i);
    on_batt = (mode == MODE_STANDBY) || (mode == MODE_RUN);
    on_reg  = (mode == MODE_RUN);
    on_chg  = (mode != MODE_OFF);
    gated_o          = '0;
    gated_o[CH_BATT] = raw_i[CH_BATT] & on_batt;
    gated_o[CH_REG]  = raw_i[CH_REG]  & on_reg;
    gated_o[CH_CHG]  = raw_i[CH_CHG]  & on_chg;
  end
endmodule

// File: rtl/status_flag.sv
module status_flag #(
  parameter bit RISE_ONLY = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic init_val_i,
  input  logic stat_i,
  input  logic clr_i,
  output logic flag_o,
  output logic stat_o
);
  logic stat_q, flag_q, event_w;

  if (RISE_ONLY) begin : g_rise
    assign event_w = stat_i & ~stat_q;
  end else begin : g_any
    assign event_w = stat_i ^ stat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (init_i) begin
      stat_q <= stat_i;
      flag_q <= init_val_i;
    end else begin
      stat_q <= stat_i;
      flag_q <= event_w | (flag_q & ~clr_i);  // set beats clear
    end
  end

  assign flag_o = flag_q;
  assign stat_o = stat_q;

  if (RISE_ONLY) begin : g_chk_rise
    assert_rise_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!init_i && stat_i && !stat_o) |=> flag_o);
    assert_fall_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!init_i && !stat_i && stat_o && !flag_o) |=> !flag_o);
  end else begin : g_chk_any
    // R4 for battery, R6 for charger
    assert_toggle_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!init_i && (stat_i != stat_o)) |=> flag_o);
  end

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && clr_i && (stat_i == stat_o)) |=> !flag_o);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !clr_i && flag_o) |=> flag_o);
  assert_set_beats_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && clr_i && stat_i && !stat_o) |=> flag_o);
endmodule

// File: rtl/status_irq_ctrl.sv
module status_irq_ctrl
  import status_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [NUM_CH-1:0] raw_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic              irq_o,
  output logic [ST_W-1:0]   status_o
);
  logic [NUM_CH-1:0] gated, init_val, flags, stats;
  logic              init_q;

  status_gate u_gate (
    .mode_i  (mode_i),
    .raw_i   (raw_i),
    .gated_o (gated)
  );

  // first cycle after reset loads power-up flag values
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b1;
    else         init_q <= 1'b0;
  end

  always_comb begin
    init_val          = '0;
    init_val[CH_BATT] = ~gated[CH_CHG];
    init_val[CH_CHG]  = gated[CH_CHG];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    status_flag #(.RISE_ONLY(i == CH_REG)) u_flag (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .init_i     (init_q),
      .init_val_i (init_val[i]),
      .stat_i     (gated[i]),
      .clr_i      (clr_i[i]),
      .flag_o     (flags[i]),
      .stat_o     (stats[i])
    );
    // serial order: battery pair first
    assign status_o[2*(NUM_CH-1-i)+1] = flags[i];
    assign status_o[2*(NUM_CH-1-i)]   = stats[i];
  end

  assign irq_o = |flags;

  assert_off_masks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF) |=> (status_o[4] == 1'b0 && status_o[2] == 1'b0 && status_o[0] == 1'b0));
  assert_lowpwr_batt_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOWPWR) |=> (status_o[4] == 1'b0));
  assert_reg_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_RUN) |=> (status_o[2] == 1'b0));
  assert_irq_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (status_o[5] | status_o[3] | status_o[1]));
  assert_powerup_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |=> (status_o[5] == ~status_o[0] && status_o[1] == status_o[0] && !status_o[3]));
endmodule

// File: tb/status_irq_ctrl_tb.sv
`timescale 1ns/1ps
module status_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [2:0] raw = 3'b000;
  logic [2:0] clr = 3'b000;
  logic       irq;
  logic [5:0] status;

  int n_run = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  status_irq_ctrl u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .mode_i   (mode),
    .raw_i    (raw),
    .clr_i    (clr),
    .irq_o    (irq),
    .status_o (status)
  );

  // reference model
  bit       m_init;
  bit [2:0] m_st, m_fl;

  function automatic bit [2:0] mask_ref(bit [1:0] m, bit [2:0] r);
    bit [2:0] g;
    g[0] = r[0] && (m == 2'b10 || m == 2'b11);
    g[1] = r[1] && (m == 2'b11);
    g[2] = r[2] && (m != 2'b00);
    return g;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_init = 1'b1; m_st = '0; m_fl = '0;
    end else begin
      bit [2:0] g;
      g = mask_ref(mode, raw);
      if (m_init) begin
        m_fl   = {g[2], 1'b0, ~g[2]};
        m_init = 1'b0;
      end else begin
        for (int i = 0; i < 3; i++) begin
          bit ev;
          ev = (i == 1) ? (g[i] && !m_st[i]) : (g[i] != m_st[i]);
          m_fl[i] = ev || (m_fl[i] && !clr[i]);
        end
      end
      m_st = g;
    end
  end

  task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R4 batt flag",  {5'b0, status[5]}, {5'b0, m_fl[0]});
      chk("R1 batt stat",  {5'b0, status[4]}, {5'b0, m_st[0]});
      chk("R5 reg flag",   {5'b0, status[3]}, {5'b0, m_fl[1]});
      chk("R2 reg stat",   {5'b0, status[2]}, {5'b0, m_st[1]});
      chk("R6 chg flag",   {5'b0, status[1]}, {5'b0, m_fl[2]});
      chk("R3 chg stat",   {5'b0, status[0]}, {5'b0, m_st[2]});
      chk("R10 irq",       {5'b0, irq},       {5'b0, |m_fl});
    end
  end

  task automatic apply(logic [1:0] m, logic [2:0] r, logic [2:0] c,
                       logic [5:0] exp, string tag);
    mode = m; raw = r; clr = c;
    @(negedge clk);
    chk(tag, status, exp);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit [15:0] lfsr;
    mode = 2'b01; raw = 3'b100; clr = 3'b000;
    repeat (3) @(negedge clk);
    chk("R9 reset status", status, 6'b000000);
    chk("R9 reset irq", {5'b0, irq}, 6'b0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    chk("R9 R11 powerup", status, 6'b000011);
    chk("R9 powerup irq", {5'b0, irq}, 6'd1);
    apply(2'b01, 3'b100, 3'b100, 6'b000001, "R7 clear chg");
    chk("R10 irq low", {5'b0, irq}, 6'd0);
    apply(2'b11, 3'b101, 3'b000, 6'b110001, "R4 R12 batt rise");
    apply(2'b11, 3'b111, 3'b001, 6'b011101, "R5 reg rise");
    apply(2'b11, 3'b101, 3'b010, 6'b010001, "R5 reg fall ignored");
    apply(2'b11, 3'b001, 3'b100, 6'b010010, "R8 set beats clear");
    apply(2'b01, 3'b011, 3'b000, 6'b100010, "R1 lowpwr mask");
    apply(2'b00, 3'b111, 3'b000, 6'b100010, "R2 R3 off mask");
    apply(2'b01, 3'b111, 3'b000, 6'b100011, "R3 R6 chg on lowpwr");
    apply(2'b10, 3'b111, 3'b111, 6'b110001, "R1 R2 standby");
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'h0) mode = lfsr[5:4];
      raw = (lfsr[8:6] == 3'b000) ? lfsr[11:9] : raw;
      clr = (lfsr[14:12] == 3'b111) ? lfsr[2:0] : 3'b000;
      @(negedge clk);
    end
    clr = 3'b000;
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule